// File: doc/BRIEF.md
# USB Device Mode Control Register

This block holds the one-byte mode control word of a USB peripheral controller and drives the signals that word governs. A host processor reaches it through a small command protocol. An opcode strobe selects a write or a read. Exactly one data strobe then follows, which either loads the word or returns it. The data bus may be wider than a byte. Only its low byte carries meaning.

Three behaviours follow from the stored word. The first is a one-cycle suspend request, raised when software drops the suspend bit from 1 to 0. The second is a level interrupt that qualifies per-transfer endpoint events. The mode chosen decides which events count: successful transfers in normal mode, NAKs and errors in debug mode. The third is the soft-connect pull-up enable, which an external pull-up select input can override.

A USB bus reset leaves the word untouched. Only the synchronous hardware reset clears it.

Top module: `usb_mode_ctl`

## Requirements
- R1: Opcode 8'hB8 on `bus_in[7:0]` with `cmd_stb`, followed by one `dat_stb`, stores the data byte into the mode word. The new value is in effect from the cycle after the data strobe.
- R2: Opcode 8'hB9 followed by one `dat_stb` returns the mode word on `rd_data[7:0]`, with all upper bits 0 and `rd_valid` high for one cycle, in the cycle after the data strobe.
- R3: Bits above bit 7 of the written data have no effect on the stored word.
- R4: Bits 7, 6, 4 and 1 of the word always read as 0, whatever value was written to them.
- R5: Bit 5 is the suspend control. `susp_pulse` is high for exactly one cycle, in the cycle after the data strobe, only when a write clears bit 5 while it held 1. Writes that go 0 to 1, 1 to 1 or 0 to 0 give no pulse.
- R6: Bit 3 is the interrupt enable. While it is 0, `irq` stays low and no pending interrupt survives.
- R7: With bit 2 (debug) at 0, two events set `irq` in the following cycle: `ev_ack` with `ev_is_iso`=0 (bulk), and `ev_iso_done` with `ev_is_iso`=1. NAKs, errors, acknowledges of isochronous endpoints and completions of bulk endpoints do not set it.
- R8: With bit 2 at 1, `ev_nak` or `ev_err` sets `irq` in the following cycle. Acknowledges and isochronous completions do not set it.
- R9: `irq` is a level. It holds until an `int_clr` strobe or a register read clears it. A qualifying event in the same cycle as a clear wins, and `irq` stays high.
- R10: `pullup_en` equals bit 0 AND NOT `ext_pull_sel`.
- R11: `usb_bus_rst` leaves every stored bit unchanged. Hardware reset `rst` clears the word, `irq`, `susp_pulse`, `rd_valid` and `pullup_en` to 0.
- R12: A data strobe with no pending valid opcode is discarded. An unknown opcode leaves the word unchanged and cancels any pending opcode. Each opcode admits only one data strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cmd_stb | input | 1 | Opcode phase strobe, opcode on bus_in[7:0] |
| dat_stb | input | 1 | Data phase strobe |
| bus_in | input | BUS_W | Command/data bus |
| usb_bus_rst | input | 1 | USB bus reset indication (keeps the word) |
| ev_ack | input | 1 | Endpoint transfer acknowledged |
| ev_nak | input | 1 | Endpoint NAK |
| ev_err | input | 1 | Endpoint transfer error |
| ev_iso_done | input | 1 | Data transfer completed |
| ev_is_iso | input | 1 | Event endpoint type: 1 isochronous, 0 bulk |
| int_clr | input | 1 | Interrupt clear strobe |
| ext_pull_sel | input | 1 | External pull-up select, 1 overrides soft connect |
| rd_data | output | BUS_W | Read data, word in the low byte |
| rd_valid | output | 1 | Read data valid, one cycle |
| susp_pulse | output | 1 | One-cycle suspend request |
| irq | output | 1 | Level interrupt |
| pullup_en | output | 1 | Soft-connect pull-up enable |

## Verification
The assertions take two things for granted: strobes are synchronous single-cycle pulses, and `cmd_stb` and `dat_stb` are never high in the same cycle. The interrupt-hold property further assumes that no write lands on the word in the cycle it checks. The stimulus raises each strobe for one cycle between falling edges and never overlaps opcode and data phases. The only intended overlap is a qualifying event arriving together with `int_clr`, which the stimulus applies on purpose to test which one wins.

// File: rtl/mode_pkg.sv
package mode_pkg;
  localparam int WORD_W   = 8;
  localparam int SUSP_BIT = 5;
  localparam int IE_BIT   = 3;
  localparam int DBG_BIT  = 2;
  localparam int SOFT_BIT = 0;
  // bits that are implemented as storage; the rest read as zero
  localparam logic [WORD_W-1:0] RW_MASK = 8'h2D;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_WR   = 2'd1,
    PEND_RD   = 2'd2
  } pend_e;

  typedef struct packed {
    logic ack;
    logic nak;
    logic err;
    logic iso_done;
    logic is_iso;
  } ep_ev_t;
endpackage

// File: rtl/mode_cmd_dec.sv
module mode_cmd_dec
  import mode_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter logic [7:0] OPC_WR = 8'hB8,
  parameter logic [7:0] OPC_RD = 8'hB9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic              dat_stb,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              wr_en,
  output logic              rd_en,
  output logic [WORD_W-1:0] wr_byte
);
  pend_e pend_q;
  logic [WORD_W-1:0] low_byte;

  assign low_byte = bus_in[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PEND_NONE;
    end else if (cmd_stb) begin
      if (low_byte == OPC_WR)      pend_q <= PEND_WR;
      else if (low_byte == OPC_RD) pend_q <= PEND_RD;
      else                         pend_q <= PEND_NONE;
    end else if (dat_stb) begin
      pend_q <= PEND_NONE;
    end
  end

  // opcode phase takes precedence over a coincident data strobe
  assign wr_en   = dat_stb && !cmd_stb && (pend_q == PEND_WR);
  assign rd_en   = dat_stb && !cmd_stb && (pend_q == PEND_RD);
  assign wr_byte = low_byte;

  generate
    if (BUS_W > WORD_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^bus_in[BUS_W-1:WORD_W];
    end
  endgenerate
endmodule

// File: rtl/mode_reg_core.sv
module mode_reg_core
  import mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_byte,
  output logic [WORD_W-1:0] mode_q,
  output logic              susp_pulse
);
  logic susp_q;
  logic unused_rsv;

  assign unused_rsv = ^(wr_byte & ~RW_MASK);

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (RW_MASK[i]) begin : g_rw
        logic bit_q;
        always_ff @(posedge clk) begin
          if (rst)        bit_q <= 1'b0;
          else if (wr_en) bit_q <= wr_byte[i];
        end
        assign mode_q[i] = bit_q;
      end else begin : g_rsv
        assign mode_q[i] = 1'b0;
      end
    end
  endgenerate

  // suspend request on a written 1-to-0 transition of the control bit
  always_ff @(posedge clk) begin
    if (rst) susp_q <= 1'b0;
    else     susp_q <= wr_en && mode_q[SUSP_BIT] && !wr_byte[SUSP_BIT];
  end

  assign susp_pulse = susp_q;
endmodule

// File: rtl/mode_irq_gen.sv
module mode_irq_gen
  import mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mode_q,
  input  ep_ev_t            ev,
  input  logic              int_clr,
  input  logic              rd_en,
  output logic              irq
);
  logic ie, dbg, hit, irq_q;
  logic unused_mode;

  assign ie  = mode_q[IE_BIT];
  assign dbg = mode_q[DBG_BIT];
  assign unused_mode = ^{mode_q[WORD_W-1:IE_BIT+1], mode_q[DBG_BIT-1:0]};

  always_comb begin
    if (dbg) hit = ev.nak || ev.err;
    else     hit = (ev.ack && !ev.is_iso) || (ev.iso_done && ev.is_iso);
    hit = hit && ie;
  end

  always_ff @(posedge clk) begin
    if (rst || !ie)             irq_q <= 1'b0;
    else if (hit)               irq_q <= 1'b1;
    else if (int_clr || rd_en)  irq_q <= 1'b0;
  end

  assign irq = irq_q && ie;
endmodule

// File: rtl/usb_mode_ctl.sv
module usb_mode_ctl
  import mode_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter logic [7:0] OPC_WR = 8'hB8,
  parameter logic [7:0] OPC_RD = 8'hB9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_stb,
  input  logic             dat_stb,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             usb_bus_rst,
  input  logic             ev_ack,
  input  logic             ev_nak,
  input  logic             ev_err,
  input  logic             ev_iso_done,
  input  logic             ev_is_iso,
  input  logic             int_clr,
  input  logic             ext_pull_sel,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             susp_pulse,
  output logic             irq,
  output logic             pullup_en
);
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] wr_byte;
  logic [WORD_W-1:0] mode_q;
  logic [BUS_W-1:0]  rd_data_q;
  logic              rd_valid_q;
  ep_ev_t            ev;
  // bus reset deliberately has no path into the stored word
  logic              unused_busrst;

  assign unused_busrst = usb_bus_rst;
  assign ev = '{ack: ev_ack, nak: ev_nak, err: ev_err,
                iso_done: ev_iso_done, is_iso: ev_is_iso};

  mode_cmd_dec #(.BUS_W(BUS_W), .OPC_WR(OPC_WR), .OPC_RD(OPC_RD)) u_dec (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .dat_stb(dat_stb),
    .bus_in(bus_in), .wr_en(wr_en), .rd_en(rd_en), .wr_byte(wr_byte)
  );

  mode_reg_core u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .mode_q(mode_q), .susp_pulse(susp_pulse)
  );

  mode_irq_gen u_irq (
    .clk(clk), .rst(rst), .mode_q(mode_q), .ev(ev),
    .int_clr(int_clr), .rd_en(rd_en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= BUS_W'(mode_q);
    end
  end

  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
  assign pullup_en = mode_q[SOFT_BIT] && !ext_pull_sel;
endmodule

// File: rtl/mode_ctl_chk.sv
module mode_ctl_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             usb_bus_rst,
  input logic             int_clr,
  input logic             ext_pull_sel,
  input logic             irq,
  input logic             susp_pulse,
  input logic             pullup_en,
  input logic             rd_valid,
  input logic [BUS_W-1:0] rd_data
);
  // R2
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data >> 8) == '0));
  // R4
  rd_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data[7:0] & 8'hD2) == 8'h00));
  // R5
  susp_width_chk: assert property (@(posedge clk) disable iff (rst)
    susp_pulse |=> !susp_pulse);
  // R5
  susp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    susp_pulse |-> ($past(mode[5]) && !mode[5]));
  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !mode[3] |-> !irq);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !int_clr && !rd_en && !wr_en) |=> irq);
  // R10
  pull_override_chk: assert property (@(posedge clk) disable iff (rst)
    ext_pull_sel |-> !pullup_en);
  // R11
  busrst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (usb_bus_rst && !wr_en) |=> (mode == $past(mode)));
endmodule

bind usb_mode_ctl mode_ctl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .wr_en(wr_en), .rd_en(rd_en),
  .usb_bus_rst(usb_bus_rst), .int_clr(int_clr), .ext_pull_sel(ext_pull_sel),
  .irq(irq), .susp_pulse(susp_pulse), .pullup_en(pullup_en),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/tb_usb_mode_ctl.sv
module tb_usb_mode_ctl;
  localparam int BUS_W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_stb = 0, dat_stb = 0, usb_bus_rst = 0;
  logic ev_ack = 0, ev_nak = 0, ev_err = 0, ev_iso_done = 0, ev_is_iso = 0;
  logic int_clr = 0, ext_pull_sel = 0;
  logic [BUS_W-1:0] bus_in = '0;
  logic [BUS_W-1:0] rd_data;
  logic rd_valid, susp_pulse, irq, pullup_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [BUS_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_mode_ctl #(.BUS_W(BUS_W)) dut (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .dat_stb(dat_stb), .bus_in(bus_in),
    .usb_bus_rst(usb_bus_rst), .ev_ack(ev_ack), .ev_nak(ev_nak), .ev_err(ev_err),
    .ev_iso_done(ev_iso_done), .ev_is_iso(ev_is_iso), .int_clr(int_clr),
    .ext_pull_sel(ext_pull_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .susp_pulse(susp_pulse), .irq(irq), .pullup_en(pullup_en)
  );

  task automatic chk(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [BUS_W-1:0] op);
    cmd_stb = 1; bus_in = op; cyc(); cmd_stb = 0; bus_in = '0;
  endtask

  task automatic send_dat(input logic [BUS_W-1:0] d);
    dat_stb = 1; bus_in = d; cyc(); dat_stb = 0; bus_in = '0;
  endtask

  // write; returns at the negedge where susp_pulse for this write is visible
  task automatic write_mode(input logic [BUS_W-1:0] d);
    send_cmd(16'h00B8); send_dat(d);
  endtask

  // driver: push expected read value, the monitor compares it
  task automatic read_mode(input logic [7:0] exp);
    send_cmd(16'h00B9);
    exp_q.push_back(BUS_W'(exp));
    send_dat('0);
    cyc();
  endtask

  task automatic ev_pulse(input logic a, input logic n, input logic e,
                          input logic d, input logic iso);
    ev_ack = a; ev_nak = n; ev_err = e; ev_iso_done = d; ev_is_iso = iso;
    cyc();
    ev_ack = 0; ev_nak = 0; ev_err = 0; ev_iso_done = 0; ev_is_iso = 0;
  endtask

  task automatic clr_pulse();
    int_clr = 1; cyc(); int_clr = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 unexpected read actual=%h expected=none", rd_data);
      end else begin
        chk("R1/R2 read data", rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc();
    // R11 reset state
    chk("R11 irq after reset", irq, 0);
    chk("R11 susp after reset", susp_pulse, 0);
    chk("R11 pullup after reset", pullup_en, 0);
    chk("R11 rd_valid after reset", rd_valid, 0);
    read_mode(8'h00);

    // R1 R3 R4: all ones written, only implemented bits stick
    write_mode(16'hFFFF);
    chk("R5 no pulse 0->1", susp_pulse, 0);
    read_mode(8'h2D);
    // R10
    chk("R10 pullup soft on", pullup_en, 1);
    ext_pull_sel = 1; cyc();
    chk("R10 pullup overridden", pullup_en, 0);
    ext_pull_sel = 0; cyc();

    write_mode(16'h002D);
    chk("R5 no pulse 1->1", susp_pulse, 0);
    write_mode(16'hFF0D);
    chk("R5 pulse on 1->0", susp_pulse, 1);
    cyc();
    chk("R5 pulse one cycle", susp_pulse, 0);
    read_mode(8'h0D);  // R3 upper byte FF ignored
    write_mode(16'h000D);
    chk("R5 no pulse 0->0", susp_pulse, 0);

    // R8 debug mode (word 0x0D: ie, dbg, soft)
    ev_pulse(1, 0, 0, 0, 0); chk("R8 bulk ack ignored in debug", irq, 0);
    ev_pulse(0, 0, 0, 1, 1); chk("R8 iso done ignored in debug", irq, 0);
    ev_pulse(0, 1, 0, 0, 0); chk("R8 nak raises", irq, 1);
    clr_pulse();             chk("R9 int_clr clears", irq, 0);
    ev_pulse(0, 0, 1, 0, 0); chk("R8 err raises", irq, 1);
    read_mode(8'h0D);
    chk("R9 read clears", irq, 0);

    // R7 normal mode
    write_mode(16'h0008);
    ev_pulse(0, 1, 0, 0, 0); chk("R7 nak ignored", irq, 0);
    ev_pulse(0, 0, 1, 0, 0); chk("R7 err ignored", irq, 0);
    ev_pulse(1, 0, 0, 0, 1); chk("R7 iso ack ignored", irq, 0);
    ev_pulse(0, 0, 0, 1, 0); chk("R7 bulk done ignored", irq, 0);
    ev_pulse(1, 0, 0, 0, 0); chk("R7 bulk ack raises", irq, 1);
    clr_pulse();             chk("R9 clear", irq, 0);
    ev_pulse(0, 0, 0, 1, 1); chk("R7 iso done raises", irq, 1);

    // R9 level hold and set-over-clear
    cyc(3);                  chk("R9 level holds", irq, 1);
    clr_pulse();
    int_clr = 1; ev_ack = 1; cyc(); int_clr = 0; ev_ack = 0;
    chk("R9 set wins over clear", irq, 1);
    clr_pulse();             chk("R9 clear after", irq, 0);

    // R6 enable off
    ev_pulse(1, 0, 0, 0, 0); chk("R6 pending before disable", irq, 1);
    write_mode(16'h0000);    chk("R6 pending dropped", irq, 0);
    ev_pulse(1, 0, 0, 0, 0); chk("R6 bulk ack gated", irq, 0);
    write_mode(16'h0004);
    ev_pulse(0, 1, 1, 0, 0); chk("R6 nak gated", irq, 0);
    write_mode(16'h000C);    chk("R6 no stale irq on enable", irq, 0);

    // R11 bus reset keeps word
    write_mode(16'h002D);
    usb_bus_rst = 1; cyc(2); usb_bus_rst = 0;
    chk("R11 no suspend from bus reset", susp_pulse, 0);
    read_mode(8'h2D);
    rst = 1; cyc(2); rst = 0; cyc();
    chk("R11 pullup after hw reset", pullup_en, 0);
    read_mode(8'h00);

    // R12 command framing
    write_mode(16'h0029);
    send_dat(16'h00FF);
    read_mode(8'h29);                     // orphan data discarded
    send_cmd(16'h0055); send_dat(16'h00FF);
    read_mode(8'h29);                     // unknown opcode
    send_cmd(16'h00B8); send_cmd(16'h0055); send_dat(16'h00FF);
    read_mode(8'h29);                     // pending opcode cancelled
    send_cmd(16'h00B8); send_dat(16'h0001); send_dat(16'h0008);
    read_mode(8'h01);                     // second data ignored
    send_cmd(16'h00B9); exp_q.push_back(BUS_W'(8'h01));
    send_dat('0); send_dat('0); cyc();
    chk("R12 one read per opcode", rd_valid, 0);
    cyc(2);

    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule